// File: doc/BRIEF.md
# Bypassable Multi-Thread Instruction Buffer

This block sits between two pipeline stages. It holds instructions from several hardware threads, each entry tagged with a thread number, a sequence number and a payload. When an instruction reaches the stage in front of the buffer, the block looks at its own occupancy and at the state of the stage two places ahead. From that it decides whether the instruction may skip the buffer and the stage after it. If the instruction cannot skip, it is queued.

Queued entries leave in arrival order through a head port. An entry can also be taken out early by naming its thread and sequence number. A squash request deletes every entry of one thread that is younger than a given sequence number. All deletions in a cycle close up the array in that same cycle, so the survivors stay contiguous from slot 0 and keep their order. Inserts are answered one cycle later with accepted or denied.

Top module: `ibuf_bypass_queue`

## Requirements
- R1: `arr_bypass` is high in the same cycle as `arr_valid` only when all three of these hold: the buffer is empty, `ds_blocked[arr_tid]` is 0, and `ds_free` is non-zero.
- R2: `arr_next_stage` equals `arr_stage + 2` when `arr_bypass` is high. Otherwise it equals `arr_stage + 1`. Both sums wrap at the width of the stage field.
- R3: `bypass_count` is 0 after reset. It increases by exactly one in the cycle after each cycle in which `arr_valid` and `arr_bypass` are both high, and it wraps at its width.
- R4: An insert is accepted when the number of entries left after that cycle's squash, remove and pop is below DEPTH. One cycle after `ins_valid`, `rsp_valid` is 1 and `rsp_ok` shows acceptance (1) or denial (0). A denied insert leaves the contents unchanged.
- R5: An accepted insert becomes the youngest entry. The `head_*` outputs show the oldest entry without removing it. `pop` deletes the entry that was at the head at the start of the cycle; a pop on an empty buffer has no effect.
- R6: `rm_valid` deletes the entry nearest the head whose thread and sequence number match `rm_tid`/`rm_seq`. The other entries keep their relative order. A remove that matches nothing changes nothing.
- R7: `sq_valid` deletes every entry whose thread equals `sq_tid` and whose sequence number is strictly greater than `sq_seq`, compared as unsigned values. Entries of other threads, and older entries, stay in place.
- R8: Squash takes precedence over an insert in the same cycle. An insert of thread `sq_tid` with a sequence number greater than `sq_seq` is dropped and answered with `rsp_ok` = 0. Inserts of other threads are processed normally.
- R9: While `rst` is high at a clock edge (synchronous, active high), all entries are cleared, `count` becomes 0, `empty` becomes 1 and `rsp_valid` becomes 0.
- R10: `count` equals the number of stored entries. `empty` is 1 exactly when `count` is 0, and `full` is 1 exactly when `count` equals DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| arr_valid | input | 1 | An instruction is arriving at the stage in front of the buffer |
| arr_tid | input | TIDW | Thread of the arriving instruction |
| arr_stage | input | STGW | Stage number of the arriving instruction |
| ds_blocked | input | 2**TIDW | Per-thread blocked flags of the stage two ahead |
| ds_free | input | FREEW | Free input slots of the stage two ahead |
| arr_bypass | output | 1 | The arriving instruction skips the buffer |
| arr_next_stage | output | STGW | Stage the arriving instruction goes to next |
| bypass_count | output | BCW | Number of bypass events |
| ins_valid | input | 1 | Insert request |
| ins_tid | input | TIDW | Thread of the inserted entry |
| ins_seq | input | SEQW | Sequence number of the inserted entry |
| ins_data | input | DATW | Payload of the inserted entry |
| rsp_valid | output | 1 | Insert response is valid (one cycle after the request) |
| rsp_ok | output | 1 | Insert was accepted |
| rm_valid | input | 1 | Remove-by-identity request |
| rm_tid | input | TIDW | Thread of the entry to remove |
| rm_seq | input | SEQW | Sequence number of the entry to remove |
| pop | input | 1 | Delete the head entry |
| sq_valid | input | 1 | Squash request |
| sq_tid | input | TIDW | Thread to squash |
| sq_seq | input | SEQW | Squash point; younger entries are deleted |
| head_valid | output | 1 | The head outputs hold an entry |
| head_tid | output | TIDW | Thread of the head entry |
| head_seq | output | SEQW | Sequence number of the head entry |
| head_data | output | DATW | Payload of the head entry |
| count | output | $clog2(DEPTH+1) | Number of stored entries |
| empty | output | 1 | Buffer is empty |
| full | output | 1 | Buffer holds DEPTH entries |

## Verification
The bypass decision and the next-stage number depend only on the current inputs and the stored state, so they are sampled in the same cycle, after the inputs settle and before the clock edge. The bypass counter, the stored contents (count, empty, full and the head fields) and the insert response all come from one register stage. The bench expects them just after the edge that follows the stimulus. The driver task updates a queue model with the request order squash, then remove, then pop, then insert. It pushes the expected insert response into a queue, and a monitor pops that queue whenever `rsp_valid` is high one cycle later.

// File: rtl/ibuf_pkg.sv
package ibuf_pkg;
  localparam int STEP_SKIP  = 2;
  localparam int STEP_QUEUE = 1;

  // Age test on sequence numbers: a is younger than b.
  function automatic logic seq_younger(input logic [31:0] a, input logic [31:0] b);
    return a > b;
  endfunction

  // Stage that an arriving instruction moves to next.
  function automatic logic [31:0] stage_after(input logic [31:0] stg, input logic skip);
    return stg + (skip ? 32'(STEP_SKIP) : 32'(STEP_QUEUE));
  endfunction
endpackage

// File: rtl/ibuf_bypass_decide.sv
module ibuf_bypass_decide #(
  parameter int TIDW  = 2,
  parameter int STGW  = 3,
  parameter int FREEW = 2
) (
  input  logic                  arr_valid,
  input  logic [TIDW-1:0]       arr_tid,
  input  logic [STGW-1:0]       arr_stage,
  input  logic [(2**TIDW)-1:0]  ds_blocked,
  input  logic [FREEW-1:0]      ds_free,
  input  logic                  buf_empty,
  output logic                  skip,
  output logic [STGW-1:0]       next_stage
);
  import ibuf_pkg::*;

  logic room_ahead, thread_open;

  always_comb begin
    room_ahead  = (ds_free != '0);
    thread_open = !ds_blocked[arr_tid];
    skip        = arr_valid && buf_empty && thread_open && room_ahead;
    next_stage  = STGW'(stage_after(32'(arr_stage), skip));
  end
endmodule

// File: rtl/ibuf_bypass_ctr.sv
module ibuf_bypass_ctr #(
  parameter int BCW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bump,
  output logic [BCW-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst)       value <= '0;
    else if (bump) value <= value + 1'b1;
  end

  assert_bypass_step_R3: assert property (@(posedge clk) disable iff (rst)
    bump |=> value == $past(value) + 1'b1);
  assert_bypass_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !bump |=> $stable(value));
endmodule

// File: rtl/ibuf_store.sv
module ibuf_store #(
  parameter int DEPTH = 8,
  parameter int TIDW  = 2,
  parameter int SEQW  = 8,
  parameter int DATW  = 16,
  localparam int CW   = $clog2(DEPTH+1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ins_valid,
  input  logic [TIDW-1:0] ins_tid,
  input  logic [SEQW-1:0] ins_seq,
  input  logic [DATW-1:0] ins_data,
  input  logic            rm_valid,
  input  logic [TIDW-1:0] rm_tid,
  input  logic [SEQW-1:0] rm_seq,
  input  logic            pop,
  input  logic            sq_valid,
  input  logic [TIDW-1:0] sq_tid,
  input  logic [SEQW-1:0] sq_seq,
  output logic            rsp_valid,
  output logic            rsp_ok,
  output logic            head_valid,
  output logic [TIDW-1:0] head_tid,
  output logic [SEQW-1:0] head_seq,
  output logic [DATW-1:0] head_data,
  output logic [CW-1:0]   count
);
  import ibuf_pkg::*;

  logic [DEPTH-1:0] vld_q;
  logic [TIDW-1:0]  tid_q [DEPTH];
  logic [SEQW-1:0]  seq_q [DEPTH];
  logic [DATW-1:0]  dat_q [DEPTH];

  logic [DEPTH-1:0] sq_kill, rm_kill, pop_kill, keep;
  logic [DEPTH-1:0] vld_n;
  logic [TIDW-1:0]  tid_n [DEPTH];
  logic [SEQW-1:0]  seq_n [DEPTH];
  logic [DATW-1:0]  dat_n [DEPTH];
  logic [CW-1:0]    surv;
  logic             ins_drop, ins_room, ins_fire;

  // Squash marks every entry of the thread that is younger than the squash point.
  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      sq_kill[i] = sq_valid && vld_q[i] && (tid_q[i] == sq_tid) &&
                   seq_younger(32'(seq_q[i]), 32'(sq_seq));
  end

  // Remove takes the match nearest the head among the entries that survive the squash.
  always_comb begin
    logic found;
    found   = 1'b0;
    rm_kill = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!found && rm_valid && vld_q[i] && !sq_kill[i] &&
          tid_q[i] == rm_tid && seq_q[i] == rm_seq) begin
        rm_kill[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  always_comb begin
    pop_kill    = '0;
    pop_kill[0] = pop && vld_q[0] && !sq_kill[0] && !rm_kill[0];
    keep        = vld_q & ~(sq_kill | rm_kill | pop_kill);
    surv        = CW'($countones(keep));
    ins_drop    = sq_valid && (ins_tid == sq_tid) &&
                  seq_younger(32'(ins_seq), 32'(sq_seq));
    ins_room    = (surv < CW'(DEPTH));
    ins_fire    = ins_valid && !ins_drop && ins_room;
  end

  // Compaction: the survivors are packed from slot 0 in their old order, then the new entry is appended.
  always_comb begin
    int rank;
    rank  = 0;
    vld_n = '0;
    for (int j = 0; j < DEPTH; j++) begin
      tid_n[j] = '0;
      seq_n[j] = '0;
      dat_n[j] = '0;
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (keep[i]) begin
        tid_n[rank] = tid_q[i];
        seq_n[rank] = seq_q[i];
        dat_n[rank] = dat_q[i];
        vld_n[rank] = 1'b1;
        rank        = rank + 1;
      end
    end
    if (ins_fire) begin
      tid_n[int'(surv)] = ins_tid;
      seq_n[int'(surv)] = ins_seq;
      dat_n[int'(surv)] = ins_data;
      vld_n[int'(surv)] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
    end else begin
      vld_q     <= vld_n;
      rsp_valid <= ins_valid;
      rsp_ok    <= ins_fire;
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
        tid_q[g] <= tid_n[g];
        seq_q[g] <= seq_n[g];
        dat_q[g] <= dat_n[g];
      end
      // No younger entry of the squashed thread is left after the squash.
      assert_squash_clean_R7: assert property (@(posedge clk) disable iff (rst)
        sq_valid |=> !(vld_q[g] && tid_q[g] == $past(sq_tid) &&
                       seq_younger(32'(seq_q[g]), 32'($past(sq_seq)))));
    end
  endgenerate

  always_comb begin
    head_valid = vld_q[0];
    head_tid   = tid_q[0];
    head_seq   = seq_q[0];
    head_data  = dat_q[0];
    count      = CW'($countones(vld_q));
  end

  assert_deny_full_R4: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && (&vld_q) && !sq_valid && !rm_valid && !pop) |=> (rsp_valid && !rsp_ok));
  assert_pop_shrinks_R5: assert property (@(posedge clk) disable iff (rst)
    (pop && vld_q[0] && !ins_valid && !sq_valid && !rm_valid) |=> count == $past(count) - 1'b1);
  assert_drop_squashed_R8: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && ins_drop) |=> (rsp_valid && !rsp_ok));
  assert_idle_head_R5: assert property (@(posedge clk) disable iff (rst)
    (!ins_valid && !sq_valid && !rm_valid && !pop) |=> ($stable(head_seq) && $stable(count)));
endmodule

// File: rtl/ibuf_bypass_queue.sv
module ibuf_bypass_queue #(
  parameter int DEPTH = 8,
  parameter int TIDW  = 2,
  parameter int SEQW  = 8,
  parameter int DATW  = 16,
  parameter int STGW  = 3,
  parameter int FREEW = 2,
  parameter int BCW   = 8,
  localparam int CW   = $clog2(DEPTH+1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 arr_valid,
  input  logic [TIDW-1:0]      arr_tid,
  input  logic [STGW-1:0]      arr_stage,
  input  logic [(2**TIDW)-1:0] ds_blocked,
  input  logic [FREEW-1:0]     ds_free,
  output logic                 arr_bypass,
  output logic [STGW-1:0]      arr_next_stage,
  output logic [BCW-1:0]       bypass_count,
  input  logic                 ins_valid,
  input  logic [TIDW-1:0]      ins_tid,
  input  logic [SEQW-1:0]      ins_seq,
  input  logic [DATW-1:0]      ins_data,
  output logic                 rsp_valid,
  output logic                 rsp_ok,
  input  logic                 rm_valid,
  input  logic [TIDW-1:0]      rm_tid,
  input  logic [SEQW-1:0]      rm_seq,
  input  logic                 pop,
  input  logic                 sq_valid,
  input  logic [TIDW-1:0]      sq_tid,
  input  logic [SEQW-1:0]      sq_seq,
  output logic                 head_valid,
  output logic [TIDW-1:0]      head_tid,
  output logic [SEQW-1:0]      head_seq,
  output logic [DATW-1:0]      head_data,
  output logic [CW-1:0]        count,
  output logic                 empty,
  output logic                 full
);
  logic bypass_event;

  always_comb begin
    empty        = (count == '0);
    full         = (count == CW'(DEPTH));
    bypass_event = arr_valid && arr_bypass;
  end

  ibuf_bypass_decide #(.TIDW(TIDW), .STGW(STGW), .FREEW(FREEW)) i_decide (
    .arr_valid(arr_valid), .arr_tid(arr_tid), .arr_stage(arr_stage),
    .ds_blocked(ds_blocked), .ds_free(ds_free), .buf_empty(empty),
    .skip(arr_bypass), .next_stage(arr_next_stage)
  );

  ibuf_bypass_ctr #(.BCW(BCW)) i_ctr (
    .clk(clk), .rst(rst), .bump(bypass_event), .value(bypass_count)
  );

  ibuf_store #(.DEPTH(DEPTH), .TIDW(TIDW), .SEQW(SEQW), .DATW(DATW)) i_store (
    .clk(clk), .rst(rst),
    .ins_valid(ins_valid), .ins_tid(ins_tid), .ins_seq(ins_seq), .ins_data(ins_data),
    .rm_valid(rm_valid), .rm_tid(rm_tid), .rm_seq(rm_seq), .pop(pop),
    .sq_valid(sq_valid), .sq_tid(sq_tid), .sq_seq(sq_seq),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
    .head_valid(head_valid), .head_tid(head_tid), .head_seq(head_seq),
    .head_data(head_data), .count(count)
  );

  assert_bypass_needs_empty_R1: assert property (@(posedge clk) disable iff (rst)
    arr_bypass |-> (count == '0 && ds_free != '0));
  assert_flags_agree_R10: assert property (@(posedge clk) disable iff (rst)
    !(empty && full));
endmodule

// File: tb/test_ibuf_bypass_queue.sv
module test_ibuf_bypass_queue;
  localparam int DEPTH = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic arr_valid = 0; logic [1:0] arr_tid = 0; logic [2:0] arr_stage = 0;
  logic [3:0] ds_blocked = 0; logic [1:0] ds_free = 0;
  logic arr_bypass; logic [2:0] arr_next_stage; logic [7:0] bypass_count;
  logic ins_valid = 0; logic [1:0] ins_tid = 0; logic [7:0] ins_seq = 0; logic [15:0] ins_data = 0;
  logic rsp_valid, rsp_ok;
  logic rm_valid = 0; logic [1:0] rm_tid = 0; logic [7:0] rm_seq = 0;
  logic pop = 0, sq_valid = 0; logic [1:0] sq_tid = 0; logic [7:0] sq_seq = 0;
  logic head_valid; logic [1:0] head_tid; logic [7:0] head_seq; logic [15:0] head_data;
  logic [3:0] count; logic empty, full;

  always #5 clk = ~clk;

  ibuf_bypass_queue i_ibuf_bypass_queue (.*);

  typedef struct { logic [1:0] t; logic [7:0] s; logic [15:0] d; } ent_t;
  ent_t mdl[$];
  bit   exp_rsp[$];
  int   n_chk = 0, n_bad = 0;
  logic [7:0] exp_bcnt = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: compares each insert response with the scoreboard entry.
  always @(posedge clk) begin
    #1;
    if (!rst && rsp_valid) begin
      if (exp_rsp.size() == 0) chk(0, "R4 unexpected response", 1, 0);
      else begin
        bit e;
        e = exp_rsp.pop_front();
        chk(rsp_ok == e, "R4/R8 insert response", rsp_ok, e);
      end
    end
  end

  // Driver: updates the model from the requirements, checks the decision before the edge and the state after it.
  task automatic tick();
    bit exp_skip;
    bit kill[$];
    ent_t nq[$];
    bit found;
    #1;
    exp_skip = arr_valid && mdl.size() == 0 && !ds_blocked[arr_tid] && ds_free != 0;
    if (arr_valid) begin
      chk(arr_bypass == exp_skip, "R1 bypass decision", arr_bypass, exp_skip);
      chk(arr_next_stage == 3'(arr_stage + (exp_skip ? 2 : 1)), "R2 next stage",
          arr_next_stage, 3'(arr_stage + (exp_skip ? 2 : 1)));
    end
    if (exp_skip) exp_bcnt++;
    found = 0;
    foreach (mdl[i]) kill.push_back(sq_valid && mdl[i].t == sq_tid && mdl[i].s > sq_seq);
    foreach (mdl[i])
      if (!found && !kill[i] && rm_valid && mdl[i].t == rm_tid && mdl[i].s == rm_seq) begin
        kill[i] = 1; found = 1;
      end
    if (pop && mdl.size() > 0) kill[0] = 1;
    foreach (mdl[i]) if (!kill[i]) nq.push_back(mdl[i]);
    if (ins_valid) begin
      bit ok;
      ok = !(sq_valid && ins_tid == sq_tid && ins_seq > sq_seq) && nq.size() < DEPTH;
      exp_rsp.push_back(ok);
      if (ok) nq.push_back('{ins_tid, ins_seq, ins_data});
    end
    mdl = nq;
    @(posedge clk); #2;
    arr_valid = 0; ins_valid = 0; rm_valid = 0; pop = 0; sq_valid = 0;
    chk(count == mdl.size(), "R10 count", count, mdl.size());
    chk(empty == (mdl.size() == 0) && full == (mdl.size() == DEPTH), "R10 flags", {empty, full},
        {mdl.size() == 0, mdl.size() == DEPTH});
    chk(bypass_count == exp_bcnt, "R3 bypass counter", bypass_count, exp_bcnt);
    if (mdl.size() > 0)
      chk(head_valid && head_tid == mdl[0].t && head_seq == mdl[0].s && head_data == mdl[0].d,
          "R5/R6/R7 head entry", head_seq, mdl[0].s);
    else chk(!head_valid, "R5 head empty", head_valid, 0);
  endtask

  task automatic put(input int t, input int s);
    ins_valid = 1; ins_tid = 2'(t); ins_seq = 8'(s); ins_data = 16'(s * 3 + 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #2;
        chk(count == 0 && empty && !full && !rsp_valid && bypass_count == 0, "R9 reset state",
            count, 0);
        rst = 0;
        // R1/R2/R3: bypass on empty buffer, then refusals.
        arr_valid = 1; arr_tid = 0; arr_stage = 3; ds_free = 1; tick();
        ds_blocked = 4'b0001; arr_valid = 1; arr_tid = 0; tick();
        arr_valid = 1; arr_tid = 1; arr_stage = 7; tick();
        ds_free = 0; arr_valid = 1; tick();
        ds_free = 2; ds_blocked = 0;
        // R4/R5: fill to capacity, then a denied insert.
        for (int k = 0; k < DEPTH; k++) begin put(k % 2, 10 + k); tick(); end
        arr_valid = 1; arr_tid = 2; tick();
        put(2, 40); tick();
        // R4: a pop in the same cycle frees room for the insert.
        put(3, 41); pop = 1; tick();
        // R6: remove a middle entry, then one that matches nothing.
        rm_valid = 1; rm_tid = 1; rm_seq = 13; tick();
        rm_valid = 1; rm_tid = 0; rm_seq = 13; tick();
        // R7: squash thread 0 younger than 12; R8 insert of same thread dropped.
        sq_valid = 1; sq_tid = 0; sq_seq = 12; put(0, 50); tick();
        // R8: other thread inserts during a squash.
        sq_valid = 1; sq_tid = 1; sq_seq = 200; put(2, 60); tick();
        sq_valid = 1; sq_tid = 3; sq_seq = 30; put(3, 20); tick();
        // R5: drain and pop on empty.
        for (int k = 0; k < DEPTH + 2; k++) begin pop = 1; tick(); end
        arr_valid = 1; arr_tid = 3; arr_stage = 6; tick();
        // R9: reset mid-run clears contents.
        put(1, 5); tick();
        rst = 1; @(posedge clk); #2; rst = 0;
        chk(count == 0 && !head_valid, "R9 reset clears", count, 0);
        chk(bypass_count == 0, "R9 counter reset", bypass_count, 0);
        exp_bcnt = 0; mdl.delete(); exp_rsp.delete();
        tick();
      end
      begin
        repeat (20000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule